// File: doc/BRIEF.md
# Deferred-Apply Device Configuration Registers

This block holds the host-side settings of a breakout-board device: a stream enable bit, an LED display mode, an LED brightness level, a reserved timing-bus configuration field and a reserved pin-direction field. Software reaches it through a register port with a write strobe, a read strobe, an address and write data. The block exports the settings to the logic that builds the slow control word and to the data path.

Each register has two copies. The shadow copy takes every write and is what reads return. The active copy is what the outputs drive. The mode register's active copy follows its shadow with no delay. The other four registers copy shadow to active only when a device reset pulse arrives. That pulse leaves the register contents as they are. Only the power-on reset input loads the power-on values.

Top module: `devcfg_bank`

## Requirements
- R1: While `rstN` is low and after it rises, before any write, the outputs and readback hold the power-on values: enable = parameter EN_POR (default 1), mode = 3, level = 7, timing-bus field = 0, direction field = 0.
- R2: A write to address 1 (mode, bits 1:0) shows on `ledMode` in the cycle after the write edge, whether or not `devReset` is high.
- R3: A write to address 0 (enable, bit 0), 2 (level, bits 3:0), 3 (timing-bus field, bits 1:0) or 4 (direction field, all DATA_W bits) does not change `streamEnable`, `ledLevel`, `harpCfg` or `gpioDir` in any cycle where `devReset` is low.
- R4: A cycle with `devReset` high copies the shadow of addresses 0, 2, 3 and 4 to their outputs, which are visible after that edge.
- R5: A `devReset` pulse leaves every stored shadow value unchanged (readback is the same before and after), and it does not change `ledMode` unless a mode write happens in the same cycle.
- R6: A read returns the shadow value of the addressed register, zero-extended, on `rdData` with `rdValid` high in the cycle after `rdEn`. Bits above a register's width are dropped on write and read back as zero. A read in the same cycle as a write to that address returns the old value.
- R7: A write to an address above 4 changes no register, and a read from one returns zero.
- R8: When a write to a deferred register and `devReset` happen in the same cycle, the output takes the newly written value.
- R9: `rdData` is zero in every cycle where `rdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| devReset | input | 1 | Device reset pulse; applies the deferred registers |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdValid | output | 1 | Read data valid, one cycle after `rdEn` |
| rdData | output | DATA_W | Read data, zero when not valid |
| streamEnable | output | 1 | Applied data-stream enable |
| ledMode | output | 2 | Applied LED display mode |
| ledLevel | output | 4 | Applied LED brightness, linear 0 to 15 |
| harpCfg | output | 2 | Applied timing-bus configuration |
| gpioDir | output | DATA_W | Applied pin-direction configuration |

## Verification
A wrong shadow value cannot be seen on the outputs until the next device reset pulse applies it. It can be seen at once on a read, one cycle after the read strobe. A wrong active value or a misplaced apply shows on the exported outputs in the cycle after the faulty edge. For this reason the bench reads the registers back between pulses and compares every output in every cycle. A decode fault that sends an out-of-range address to a real register shows up the next time that register is read back.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int NUM_REGS = 5;

  localparam int IDX_ENABLE = 0;
  localparam int IDX_MODE   = 1;
  localparam int IDX_LEVEL  = 2;
  localparam int IDX_HARP   = 3;
  localparam int IDX_GPIO   = 4;

  localparam int ENABLE_W = 1;
  localparam int MODE_W   = 2;
  localparam int LEVEL_W  = 4;
  localparam int HARP_W   = 2;

  localparam logic [3:0] MODE_POR  = 4'd3;
  localparam logic [3:0] LEVEL_POR = 4'd7;

  // Strobes from the decode/control half to the storage half.
  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic [NUM_REGS-1:0] rdSel;
    logic                rdStb;
    logic                apply;
  } ctlStrobes_t;

  // Significant width of each register; the last one spans the data bus.
  function automatic int regWidth(input int idx, input int dataW);
    case (idx)
      IDX_ENABLE: return ENABLE_W;
      IDX_MODE:   return MODE_W;
      IDX_LEVEL:  return LEVEL_W;
      IDX_HARP:   return HARP_W;
      default:    return dataW;
    endcase
  endfunction

  // Only the mode register takes effect without waiting for a device reset.
  function automatic bit isDeferred(input int idx);
    return idx != IDX_MODE;
  endfunction

endpackage

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              devReset,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes
);

  logic [NUM_REGS-1:0] hit;

  // Address decode: at most one hit; out-of-range addresses select nothing.
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      hit[i] = (int'(addr) == i);
    end
  end

  always_comb begin
    strobes.wrSel = wrEn ? hit : '0;
    strobes.rdSel = rdEn ? hit : '0;
    strobes.rdStb = rdEn;
    strobes.apply = devReset;
  end

endmodule

// File: rtl/cfgbank_dpath.sv
module cfgbank_dpath
  import cfgbank_pkg::*;
#(
  parameter int   DATA_W = 16,
  parameter logic EN_POR = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobes_t                      strobes,
  input  logic [DATA_W-1:0]                wrData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  activeQ,
  output logic                             rdValid,
  output logic [DATA_W-1:0]                rdData
);

  logic [NUM_REGS-1:0][DATA_W-1:0] shadowQ;
  logic [NUM_REGS-1:0][DATA_W-1:0] shadowNext;
  logic [DATA_W-1:0]               rdMux;

  function automatic logic [DATA_W-1:0] fieldMask(input int idx);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) begin
      m[b] = (b < regWidth(idx, DATA_W));
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] porValue(input int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    case (idx)
      IDX_ENABLE: v[0]   = EN_POR;
      IDX_MODE:   v[3:0] = MODE_POR;
      IDX_LEVEL:  v[3:0] = LEVEL_POR;
      default:    v      = '0;
    endcase
    return v & fieldMask(idx);
  endfunction

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
      localparam logic [DATA_W-1:0] MASK = fieldMask(g);
      localparam logic [DATA_W-1:0] POR  = porValue(g);

      assign shadowNext[g] = strobes.wrSel[g] ? (wrData & MASK) : shadowQ[g];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shadowQ[g] <= POR;
        else       shadowQ[g] <= shadowNext[g];
      end

      if (isDeferred(g)) begin : gDeferred
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)              activeQ[g] <= POR;
          else if (strobes.apply) activeQ[g] <= shadowNext[g];
        end
      end else begin : gImmediate
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) activeQ[g] <= POR;
          else       activeQ[g] <= shadowNext[g];
        end
      end
    end
  endgenerate

  // Readback returns the shadow copy as it stood before this edge.
  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobes.rdSel[i]) rdMux = rdMux | shadowQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdStb;
      rdData  <= strobes.rdStb ? rdMux : '0;
    end
  end

endmodule

// File: rtl/devcfg_bank.sv
module devcfg_bank
  import cfgbank_pkg::*;
#(
  parameter int   ADDR_W = 8,
  parameter int   DATA_W = 16,
  parameter logic EN_POR = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               devReset,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               streamEnable,
  output logic [MODE_W-1:0]  ledMode,
  output logic [LEVEL_W-1:0] ledLevel,
  output logic [HARP_W-1:0]  harpCfg,
  output logic [DATA_W-1:0]  gpioDir
);

  ctlStrobes_t                     strobes;
  logic [NUM_REGS-1:0][DATA_W-1:0] activeQ;

  cfgbank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .devReset (devReset),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .strobes  (strobes)
  );

  cfgbank_dpath #(.DATA_W(DATA_W), .EN_POR(EN_POR)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .activeQ (activeQ),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  assign streamEnable = activeQ[IDX_ENABLE][0];
  assign ledMode      = activeQ[IDX_MODE][MODE_W-1:0];
  assign ledLevel     = activeQ[IDX_LEVEL][LEVEL_W-1:0];
  assign harpCfg      = activeQ[IDX_HARP][HARP_W-1:0];
  assign gpioDir      = activeQ[IDX_GPIO];

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               devReset,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic               rdValid,
  input logic [DATA_W-1:0]  rdData,
  input logic               streamEnable,
  input logic [MODE_W-1:0]  ledMode,
  input logic [LEVEL_W-1:0] ledLevel,
  input logic [HARP_W-1:0]  harpCfg,
  input logic [DATA_W-1:0]  gpioDir
);

  AST_MODE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == IDX_MODE) |=> ledMode == $past(wrData[MODE_W-1:0])); // R2

  AST_DEFERRED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !devReset |=> ($stable(streamEnable) && $stable(ledLevel) && $stable(harpCfg) && $stable(gpioDir))); // R3

  AST_MODE_KEPT_ON_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    (devReset && !(wrEn && int'(addr) == IDX_MODE)) |=> $stable(ledMode)); // R5

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R6

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) >= NUM_REGS) |=> rdData == '0); // R7

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == '0); // R9

endmodule

bind devcfg_bank cfgbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .devReset     (devReset),
  .wrEn         (wrEn),
  .rdEn         (rdEn),
  .addr         (addr),
  .wrData       (wrData),
  .rdValid      (rdValid),
  .rdData       (rdData),
  .streamEnable (streamEnable),
  .ledMode      (ledMode),
  .ledLevel     (ledLevel),
  .harpCfg      (harpCfg),
  .gpioDir      (gpioDir)
);

// File: tb/devcfg_bank_tb_top.sv
module devcfg_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int WATCHDOG   = 5000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              devReset = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic              streamEnable;
  logic [1:0]        ledMode;
  logic [3:0]        ledLevel;
  logic [1:0]        harpCfg;
  logic [DATA_W-1:0] gpioDir;

  devcfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_POR(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .devReset(devReset), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .streamEnable(streamEnable), .ledMode(ledMode), .ledLevel(ledLevel),
    .harpCfg(harpCfg), .gpioDir(gpioDir)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: plain integers per register.
  int    shadow [5];
  int    active [5];
  int    expRdValid;
  int    expRdData;
  int    nCompared = 0;
  int    nMismatch = 0;
  bit    finished = 0;
  string curReq = "R1";

  function automatic int widthOf(int i);
    case (i)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 2;
      default: return DATA_W;
    endcase
  endfunction

  function automatic int maskOf(int i);
    return (1 << widthOf(i)) - 1;
  endfunction

  function automatic int porOf(int i);
    case (i)
      0: return 1;
      1: return 3;
      2: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic modelPowerOn();
    for (int i = 0; i < 5; i++) begin
      shadow[i] = porOf(i);
      active[i] = porOf(i);
    end
    expRdValid = 0;
    expRdData  = 0;
  endtask

  task automatic modelEdge(bit we, bit re, int a, int d, bit dr);
    expRdValid = re ? 1 : 0;
    expRdData  = (re && a < 5) ? shadow[a] : 0;
    if (we && a < 5) shadow[a] = d & maskOf(a);
    for (int i = 0; i < 5; i++) begin
      if (i == 1 || dr) active[i] = shadow[i];
    end
  endtask

  task automatic cmp(string what, int act, int exp);
    nCompared++;
    if (act != exp) begin
      nMismatch++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    cmp("rdValid", int'(rdValid), expRdValid);
    cmp("rdData", int'(rdData), expRdData);
    cmp("streamEnable", int'(streamEnable), active[0] & 1);
    cmp("ledMode", int'(ledMode), active[1]);
    cmp("ledLevel", int'(ledLevel), active[2]);
    cmp("harpCfg", int'(harpCfg), active[3]);
    cmp("gpioDir", int'(gpioDir), active[4]);
  endtask

  // One clock: drive at the falling edge, model the rising edge, compare at the next fall.
  task automatic cyc(bit we, bit re, int a, int d, bit dr);
    wrEn     = we;
    rdEn     = re;
    addr     = ADDR_W'(a);
    wrData   = DATA_W'(d);
    devReset = dr;
    @(posedge clk);
    modelEdge(we, re, a, d, dr);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic readAll();
    for (int a = 0; a < 5; a++) cyc(0, 1, a, 0, 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  endtask

  initial begin
    modelPowerOn();
    // R1: power-on values during and after reset
    curReq = "R1";
    repeat (3) @(negedge clk);
    compareAll();
    rstN = 1'b1;
    idle(2);
    readAll();

    // R2: mode write shows at once, twice in a row
    curReq = "R2";
    cyc(1, 0, 1, 2, 0);
    cyc(1, 0, 1, 16'hFFF0, 0);
    cyc(1, 0, 1, 1, 0);

    // R3: deferred writes do not move the outputs
    curReq = "R3";
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 2, 12, 0);
    cyc(1, 0, 3, 3, 0);
    cyc(1, 0, 4, 16'hA5C3, 0);
    idle(3);

    // R6: readback is the shadow copy, upper bits dropped, read-during-write sees the old value
    curReq = "R6";
    readAll();
    cyc(1, 0, 2, 16'hFFF9, 0);
    cyc(0, 1, 2, 0, 0);
    cyc(1, 1, 3, 1, 0);
    cyc(0, 1, 3, 0, 0);

    // R4: device reset applies the deferred registers
    curReq = "R4";
    cyc(0, 0, 0, 0, 1);
    idle(1);

    // R5: shadow values and mode survive the pulse
    curReq = "R5";
    readAll();
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    readAll();

    // R8: write and device reset in the same cycle
    curReq = "R8";
    cyc(1, 0, 2, 5, 1);
    cyc(1, 0, 0, 1, 1);
    cyc(1, 0, 4, 16'h1234, 1);
    cyc(1, 0, 1, 0, 1);
    readAll();

    // R7: unmapped addresses
    curReq = "R7";
    cyc(1, 0, 5, 16'hFFFF, 0);
    cyc(1, 0, 7, 16'hFFFF, 0);
    cyc(1, 0, 255, 16'hFFFF, 1);
    cyc(0, 1, 5, 0, 0);
    cyc(0, 1, 255, 0, 0);
    readAll();

    // R9: idle read data
    curReq = "R9";
    idle(4);

    // R1: power-on reset again after activity
    curReq = "R1";
    @(negedge clk);
    rstN = 1'b0;
    modelPowerOn();
    @(negedge clk);
    compareAll();
    rstN = 1'b1;
    idle(1);
    readAll();

    finish();
  end

  initial begin
    for (int k = 0; k < WATCHDOG; k++) @(posedge clk);
    nMismatch++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    finish();
  end

endmodule